// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits for a four-beat burst. On a load cycle it captures an externally supplied two-bit offset. On each continue cycle it steps to the next word of the aligned four-word block. The step order follows one of two sequences, picked by a static order-select input. The linear sequence counts upward and wraps within the block. The interleaved sequence flips the offset bits according to the beat number.

A single free-running beat counter drives both orders. The address seen on the output is a combinational function of the stored start offset and the beat count. An active-low clock enable stalls the whole block: while it is inactive, the stored state does not change. The upper address bits, command decoding and memory access are handled outside this block.

Top module: `lowaddr_burst_seq`

## Requirements
- R1: On a rising edge with `clk_en_n` low and `load_n` low, the block captures `ext_low`. After that edge `burst_low` equals the captured value and `beat_idx` is 0.
- R2: On a rising edge with `clk_en_n` low and `load_n` high, `beat_idx` increases by one modulo 4. This happens whatever the cycle type on the surrounding bus, so dummy reads and aborted writes also advance it.
- R3: With `order_sel` = 0 (linear), `burst_low` equals (start + `beat_idx`) mod 4. For example, starting at 01 gives 01, 10, 11, 00, and starting at 10 gives 10, 11, 00, 01.
- R4: With `order_sel` = 1 (interleaved), `burst_low` equals start XOR `beat_idx`. For example, starting at 01 gives 01, 00, 11, 10, and starting at 11 gives 11, 10, 01, 00.
- R5: On a rising edge with `clk_en_n` high, `burst_low` and `beat_idx` keep their values, and `load_n` and `ext_low` have no effect.
- R6: On a rising edge with `rst_n` low, `burst_low` becomes 00 and `beat_idx` becomes 0.
- R7: After four advances from a load, `burst_low` is back at the start offset, and the same four-word sequence repeats if advancing continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; when high the edge is ignored |
| load_n | input | 1 | Low: load a new start offset; high: advance the burst |
| order_sel | input | 1 | Static order select: 0 = linear, 1 = interleaved |
| ext_low | input | 2 | External low address bits captured on a load |
| burst_low | output | 2 | Current low address bits of the burst |
| beat_idx | output | 2 | Beat number since the last load, modulo 4 |

## Verification
The hardest case to reach is a stall that falls in the middle of a burst, in either order. During the stall, `load_n` and `ext_low` are driven with values that would disturb the state if the edge were not ignored. The stimulus covers every start offset in both orders. It runs eight advances after each load so that the wrap past the fourth beat is exercised, and it inserts stalls at pseudo-random points with a random load strobe and a random offset. Each stall is checked right after its edge, before the next advance.

// File: rtl/lowaddr_pkg.sv
// Shared types for the low-address burst sequencer.
package lowaddr_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/lowaddr_beat_ctr.sv
// Beat counter: clears on a restart and steps by one on an advance.
// Assumes restart and advance are mutually exclusive. Both are already
// qualified by the clock enable.
module lowaddr_beat_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         advance,
    output logic [W-1:0] beat_q
);
    // Update the beat count; it holds when neither strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n)       beat_q <= '0;
        else if (restart) beat_q <= '0;
        else if (advance) beat_q <= beat_q + W'(1);
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (beat_q == '0)); // R1
    AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart) |=> (beat_q == W'($past(beat_q) + W'(1)))); // R2
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !restart) |=> $stable(beat_q)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (beat_q == '0)); // R6
endmodule

// File: rtl/lowaddr_start_reg.sv
// Start-offset register: holds the external low bits captured on a load.
// Assumes the capture strobe is already qualified by the clock enable.
module lowaddr_start_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] ext_in,
    output logic [W-1:0] start_q
);
    // Capture the burst start offset on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)       start_q <= '0;
        else if (capture) start_q <= ext_in;
    end

    AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(start_q)); // R5
endmodule

// File: rtl/lowaddr_order_map.sv
// Order mapping: combines the start offset and the beat count into the
// current address. Linear adds them modulo 2**W; interleaved XORs them.
module lowaddr_order_map #(
    parameter int W = 2
) (
    input  lowaddr_pkg::order_e order,
    input  logic [W-1:0]        start,
    input  logic [W-1:0]        beat,
    output logic [W-1:0]        addr
);
    // Pick the sequence rule for the selected order.
    always_comb begin
        case (order)
            lowaddr_pkg::ORD_LINEAR: addr = start + beat;
            default:                 addr = start ^ beat;
        endcase
    end
endmodule

// File: rtl/lowaddr_burst_seq.sv
// Top level of the burst low-address sequencer. It qualifies the
// load/advance strobe with the active-low clock enable, keeps the start
// offset and the beat count, and maps them into the burst address.
// Assumes order_sel is static while bursts are in flight.
module lowaddr_burst_seq #(
    parameter int LOW_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en_n,
    input  logic                load_n,
    input  logic                order_sel,
    input  logic [LOW_BITS-1:0] ext_low,
    output logic [LOW_BITS-1:0] burst_low,
    output logic [LOW_BITS-1:0] beat_idx
);
    import lowaddr_pkg::*;

    localparam int W = LOW_BITS;

    logic         do_load;
    logic         do_adv;
    logic [W-1:0] start_q;
    order_e       order;

    // Gate the load and advance strobes with the clock enable.
    always_comb begin
        do_load = !clk_en_n && !load_n;
        do_adv  = !clk_en_n &&  load_n;
        order   = order_e'(order_sel);
    end

    lowaddr_start_reg #(.W(W)) u_start (
        .clk(clk), .rst_n(rst_n), .capture(do_load),
        .ext_in(ext_low), .start_q(start_q)
    );

    lowaddr_beat_ctr #(.W(W)) u_beat (
        .clk(clk), .rst_n(rst_n), .restart(do_load),
        .advance(do_adv), .beat_q(beat_idx)
    );

    lowaddr_order_map #(.W(W)) u_map (
        .order(order), .start(start_q), .beat(beat_idx), .addr(burst_low)
    );

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n) |=> (burst_low == $past(ext_low))); // R1
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && !order_sel) |=>
        (order_sel || burst_low == W'($past(burst_low) + W'(1)))); // R3
    AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && order_sel) |=>
        (!order_sel || (burst_low ^ $past(burst_low)) == (beat_idx ^ $past(beat_idx)))); // R4
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(beat_idx) && (order_sel != $past(order_sel) || $stable(burst_low)))); // R5
    AST_RESET_ADDR: assert property (@(posedge clk)
        !rst_n |=> (burst_low == '0)); // R6
endmodule

// File: tb/lowaddr_burst_seq_test.sv
module lowaddr_burst_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en_n = 1'b1;
    logic       load_n = 1'b1;
    logic       order_sel = 1'b1;
    logic [1:0] ext_low = 2'b00;
    logic [1:0] burst_low;
    logic [1:0] beat_idx;

    int checks = 0;
    int fails = 0;
    logic [1:0] m_start = 2'b00;
    logic [1:0] m_beat = 2'b00;

    always #5 clk = ~clk;

    lowaddr_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
        .order_sel(order_sel), .ext_low(ext_low),
        .burst_low(burst_low), .beat_idx(beat_idx)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] model_addr(input logic ord, input logic [1:0] s, input logic [1:0] b);
        return ord ? (s ^ b) : 2'((s + b) & 2'b11);
    endfunction

    // One clock: drive at the falling edge, sample 1 ns after the rise.
    task automatic cycle(input logic en_n, input logic ld_n, input logic [1:0] ext);
        @(negedge clk);
        clk_en_n = en_n; load_n = ld_n; ext_low = ext;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R6: reset state
        cycle(1'b0, 1'b0, 2'b11);
        check("R6 reset burst_low", burst_low, 2'b00);
        check("R6 reset beat_idx", beat_idx, 2'b00);
        @(negedge clk); rst_n = 1'b1;

        for (int ord = 0; ord < 2; ord++) begin
            order_sel = ord[0];
            for (int s = 0; s < 4; s++) begin
                // R1: load
                cycle(1'b0, 1'b0, s[1:0]);
                m_start = s[1:0]; m_beat = 2'b00;
                check("R1 load burst_low", burst_low, m_start);
                check("R1 load beat_idx", beat_idx, 2'b00);
                for (int k = 1; k <= 8; k++) begin
                    if ($urandom_range(0, 2) == 0) begin
                        // R5: stall with disturbing inputs
                        cycle(1'b1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
                        check("R5 stall burst_low", burst_low, model_addr(order_sel, m_start, m_beat));
                        check("R5 stall beat_idx", beat_idx, m_beat);
                    end
                    // R2: advance
                    cycle(1'b0, 1'b1, 2'($urandom_range(0, 3)));
                    m_beat = m_beat + 2'd1;
                    check("R2 advance beat_idx", beat_idx, m_beat);
                    if (ord == 0) check("R3 linear burst_low", burst_low, model_addr(1'b0, m_start, m_beat));
                    else          check("R4 interleaved burst_low", burst_low, model_addr(1'b1, m_start, m_beat));
                    if (k == 4 || k == 8) check("R7 wrap to start", burst_low, m_start);
                end
            end
        end

        // R6: reset mid-burst
        cycle(1'b0, 1'b0, 2'b10);
        cycle(1'b0, 1'b1, 2'b00);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R6 mid-burst reset burst_low", burst_low, 2'b00);
        check("R6 mid-burst reset beat_idx", beat_idx, 2'b00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule